// File: doc/BRIEF.md
# Bus Hold Arbiter with Interrupt Output

This block runs the handshake by which an external bus master borrows the CPU's external bus. The master pulls an active-low hold request. The request passes through a synchronizer. If the protocol is enabled, the arbiter waits for the bus to reach an idle point between cycles. It then hands the bus over and drives an active-low hold acknowledge.

While the bus is lent out, an interrupt may become pending. The arbiter then signals outward in one of two ways. If code runs from internal memory, the CPU needs no bus, so the active-low interrupt output is raised at once. If code runs from external memory, the arbiter first raises an active-low bus request asking the master to give the bus back. It raises the interrupt output only when the master lets go.

There is one special case: code runs from external memory and the interrupt arrives after the request was seen but before the grant. The grant and the interrupt output are then raised together and held until the master releases. All outputs are registered.

Top module: `bus_hold_arbiter`

## Requirements
- R1: A synchronous active-high reset drives hold_ack_n, bus_req_n and int_out_n high (inactive) on the next clock edge, and the arbiter returns to idle.
- R2: While hold_en is 0, a low hold_req_n is ignored: hold_ack_n stays high.
- R3: With hold_en at 1 and bus_idle at 1, hold_ack_n goes low on the fourth rising clock edge after hold_req_n goes low. Two of those edges are the synchronizer and two are the arbiter.
- R4: While a request is pending and bus_idle is 0, hold_ack_n stays high. It goes low on the first edge at which bus_idle has been seen at 1.
- R5: When hold_req_n returns high, hold_ack_n and bus_req_n go high on the third rising edge after the change.
- R6: In hold with code_ext at 0 (internal code), a pending interrupt drives int_out_n low on the next edge, and bus_req_n stays high.
- R7: In hold with code_ext at 1 (external code), a pending interrupt drives bus_req_n low on the next edge while int_out_n stays high. int_out_n goes low on the same edge that releases hold_ack_n. bus_req_n and int_out_n are never low together.
- R8: Outside the grant, int_out_n goes high on the edge after irq_pend falls.
- R9: With code_ext at 1, an interrupt that becomes pending between the synchronized request and the grant makes hold_ack_n and int_out_n go low on the same edge, with bus_req_n high. int_out_n then stays low until the hold is released, even if irq_pend clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_en | input | 1 | Enables the hold protocol |
| hold_req_n | input | 1 | Hold request from the external master, active low, asynchronous |
| irq_pend | input | 1 | An interrupt is pending, active high |
| code_ext | input | 1 | 1: code runs from external memory; 0: internal |
| bus_idle | input | 1 | The bus is between cycles and may be handed over |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| bus_req_n | output | 1 | Request to take the bus back, active low |
| int_out_n | output | 1 | Interrupt needs the bus, active low |

## Verification
The handshake is driven with the enable both clear and set, and with the bus both busy and idle at the moment of request. These runs separate the gating, the synchronizer latency and the wait for a cycle boundary.

Interrupts are then raised in three places. The first is in hold with internal code, and the second is in hold with external code. The third is in the window between request and grant with external code. Each placement selects a different pairing of bus request and interrupt output, and a different point at which each one falls and clears.

A reset issued mid-hold shows that every output returns inactive in one edge.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_HOLD = 2'd2,
        ST_REL  = 2'd3
    } hold_state_e;

    // Active-high internal view of the three outputs
    typedef struct packed {
        logic grant;
        logic breq;
        logic intout;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_QUIET = '{grant: 1'b0, breq: 1'b0, intout: 1'b0};

    function automatic bus_ctl_t next_ctl(
        input hold_state_e nxt,
        input logic        early_nxt,
        input logic        irq_pend,
        input logic        code_ext,
        input logic        intout_q
    );
        bus_ctl_t c;
        c.grant  = (nxt == ST_HOLD);
        c.breq   = (nxt == ST_HOLD) && code_ext && irq_pend && !early_nxt;
        c.intout = ((nxt == ST_HOLD) && early_nxt)
                || ((nxt == ST_HOLD) && !code_ext && irq_pend)
                || ((nxt == ST_REL) && code_ext && irq_pend)
                || (intout_q && irq_pend);
        return c;
    endfunction

endpackage

// File: rtl/hold_req_sync.sv
module hold_req_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;
    logic [STAGES-1:0] src;

    assign src = {chain[STAGES-2:0], din};

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= RST_VAL;
            else     chain[i] <= src[i];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/hold_arb_fsm.sv
module hold_arb_fsm
    import hold_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hold_en,
    input  logic        req_s,
    input  logic        bus_idle,
    input  logic        irq_pend,
    input  logic        code_ext,
    output hold_state_e state_q,
    output hold_state_e state_nxt,
    output logic        early_nxt
);
    logic early_q;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (hold_en && req_s) state_nxt = ST_PEND;
            ST_PEND: begin
                if (!req_s)        state_nxt = ST_IDLE;
                else if (bus_idle) state_nxt = ST_HOLD;
            end
            ST_HOLD: if (!req_s) state_nxt = ST_REL;
            ST_REL:  state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Interrupt seen in the window between request and grant (external code)
    always_comb begin
        if (state_nxt == ST_IDLE)
            early_nxt = 1'b0;
        else if (state_q == ST_PEND && code_ext && irq_pend)
            early_nxt = 1'b1;
        else
            early_nxt = early_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            early_q <= 1'b0;
        end else begin
            state_q <= state_nxt;
            early_q <= early_nxt;
        end
    end
endmodule

// File: rtl/hold_arb_outs.sv
module hold_arb_outs
    import hold_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  hold_state_e state_nxt,
    input  logic        early_nxt,
    input  logic        irq_pend,
    input  logic        code_ext,
    output bus_ctl_t    ctl_q
);
    bus_ctl_t ctl_d;

    always_comb ctl_d = next_ctl(state_nxt, early_nxt, irq_pend, code_ext, ctl_q.intout);

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_QUIET;
        else     ctl_q <= ctl_d;
    end
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
    import hold_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_en,
    input  logic hold_req_n,
    input  logic irq_pend,
    input  logic code_ext,
    input  logic bus_idle,
    output logic hold_ack_n,
    output logic bus_req_n,
    output logic int_out_n
);
    logic        req_n_s;
    logic        req_s;
    hold_state_e state_q;
    hold_state_e state_nxt;
    logic        early_nxt;
    bus_ctl_t    ctl_q;

    hold_req_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (hold_req_n),
        .dout (req_n_s)
    );

    assign req_s = ~req_n_s;

    hold_arb_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hold_en   (hold_en),
        .req_s     (req_s),
        .bus_idle  (bus_idle),
        .irq_pend  (irq_pend),
        .code_ext  (code_ext),
        .state_q   (state_q),
        .state_nxt (state_nxt),
        .early_nxt (early_nxt)
    );

    hold_arb_outs u_outs (
        .clk       (clk),
        .rst       (rst),
        .state_nxt (state_nxt),
        .early_nxt (early_nxt),
        .irq_pend  (irq_pend),
        .code_ext  (code_ext),
        .ctl_q     (ctl_q)
    );

    assign hold_ack_n = ~ctl_q.grant;
    assign bus_req_n  = ~ctl_q.breq;
    assign int_out_n  = ~ctl_q.intout;
endmodule

// File: rtl/bus_hold_arbiter_chk.sv
module bus_hold_arbiter_chk
    import hold_arb_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        hold_en,
    input logic        irq_pend,
    input logic        hold_ack_n,
    input logic        bus_req_n,
    input logic        int_out_n,
    input hold_state_e state_q
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (hold_ack_n && bus_req_n && int_out_n)); // R1

    AST_DISABLED_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !hold_en) |=> (state_q == ST_IDLE)); // R2

    AST_RELEASE_DROPS_BREQ: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_ack_n) |-> bus_req_n); // R5

    AST_BREQ_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        !bus_req_n |-> !hold_ack_n); // R7

    AST_BREQ_INTOUT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!bus_req_n && !int_out_n)); // R7

    AST_INTOUT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !irq_pend |=> (int_out_n || !hold_ack_n)); // R8
endmodule

bind bus_hold_arbiter bus_hold_arbiter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hold_en    (hold_en),
    .irq_pend   (irq_pend),
    .hold_ack_n (hold_ack_n),
    .bus_req_n  (bus_req_n),
    .int_out_n  (int_out_n),
    .state_q    (state_q)
);

// File: tb/bus_hold_arbiter_bench.sv
`timescale 1ns/1ps
module bus_hold_arbiter_bench;
    logic clk = 1'b0;
    logic rst, hold_en, hold_req_n, irq_pend, code_ext, bus_idle;
    logic hold_ack_n, bus_req_n, int_out_n;
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bus_hold_arbiter u_bus_hold_arbiter (
        .clk        (clk),
        .rst        (rst),
        .hold_en    (hold_en),
        .hold_req_n (hold_req_n),
        .irq_pend   (irq_pend),
        .code_ext   (code_ext),
        .bus_idle   (bus_idle),
        .hold_ack_n (hold_ack_n),
        .bus_req_n  (bus_req_n),
        .int_out_n  (int_out_n)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic ea, input logic eb, input logic ei);
        check(tag, "hold_ack_n", hold_ack_n, ea);
        check(tag, "bus_req_n",  bus_req_n,  eb);
        check(tag, "int_out_n",  int_out_n,  ei);
    endtask

    task automatic go_idle();
        hold_req_n = 1'b1; irq_pend = 1'b0; bus_idle = 1'b1; hold_en = 1'b1;
        tick(5);
    endtask

    task automatic t_reset();
        rst = 1'b1; hold_en = 1'b1; hold_req_n = 1'b1; irq_pend = 1'b0;
        code_ext = 1'b0; bus_idle = 1'b1;
        tick(3);
        check_all("R1", 1'b1, 1'b1, 1'b1);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic t_disabled();
        hold_en = 1'b0; hold_req_n = 1'b0; bus_idle = 1'b1;
        tick(8);
        check("R2", "hold_ack_n while disabled", hold_ack_n, 1'b1);
        go_idle();
    endtask

    task automatic t_latency_and_release();
        hold_req_n = 1'b0; bus_idle = 1'b1;
        tick(3);
        check("R3", "hold_ack_n after 3 edges", hold_ack_n, 1'b1);
        tick(1);
        check("R3", "hold_ack_n after 4 edges", hold_ack_n, 1'b0);
        hold_req_n = 1'b1;
        tick(2);
        check("R5", "hold_ack_n 2 edges after release", hold_ack_n, 1'b0);
        tick(1);
        check_all("R5", 1'b1, 1'b1, 1'b1);
        go_idle();
    endtask

    task automatic t_bus_busy();
        bus_idle = 1'b0; hold_req_n = 1'b0;
        tick(7);
        check("R4", "hold_ack_n while bus busy", hold_ack_n, 1'b1);
        bus_idle = 1'b1;
        tick(1);
        check("R4", "hold_ack_n once bus idle", hold_ack_n, 1'b0);
        go_idle();
    endtask

    task automatic t_internal_irq();
        code_ext = 1'b0; hold_req_n = 1'b0; bus_idle = 1'b1;
        tick(4);
        irq_pend = 1'b1;
        tick(1);
        check_all("R6", 1'b0, 1'b1, 1'b0);
        irq_pend = 1'b0;
        tick(1);
        check("R8", "int_out_n after irq clear (internal)", int_out_n, 1'b1);
        go_idle();
    endtask

    task automatic t_external_irq();
        code_ext = 1'b1; hold_req_n = 1'b0; bus_idle = 1'b1;
        tick(4);
        irq_pend = 1'b1;
        tick(1);
        check_all("R7", 1'b0, 1'b0, 1'b1);
        tick(3);
        check_all("R7", 1'b0, 1'b0, 1'b1);
        hold_req_n = 1'b1;
        tick(3);
        check_all("R7", 1'b1, 1'b1, 1'b0);
        tick(2);
        check("R8", "int_out_n held while irq pending", int_out_n, 1'b0);
        irq_pend = 1'b0;
        tick(1);
        check("R8", "int_out_n after irq clear (external)", int_out_n, 1'b1);
        go_idle();
    endtask

    task automatic t_early_irq();
        code_ext = 1'b1; bus_idle = 1'b0; hold_req_n = 1'b0;
        tick(3);
        irq_pend = 1'b1;
        tick(1);
        check_all("R9", 1'b1, 1'b1, 1'b1);
        bus_idle = 1'b1;
        tick(1);
        check_all("R9", 1'b0, 1'b1, 1'b0);
        irq_pend = 1'b0;
        tick(2);
        check_all("R9", 1'b0, 1'b1, 1'b0);
        hold_req_n = 1'b1;
        tick(3);
        check_all("R9", 1'b1, 1'b1, 1'b1);
        go_idle();
    endtask

    task automatic t_reset_mid_hold();
        code_ext = 1'b0; hold_req_n = 1'b0; bus_idle = 1'b1;
        tick(4);
        irq_pend = 1'b1;
        tick(1);
        check("R1", "int_out_n before reset", int_out_n, 1'b0);
        rst = 1'b1;
        tick(1);
        check_all("R1", 1'b1, 1'b1, 1'b1);
        rst = 1'b0;
        go_idle();
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_latency_and_release();
        t_bus_busy();
        t_internal_irq();
        t_external_irq();
        t_early_irq();
        t_reset_mid_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule